// File: doc/BRIEF.md
# Periodic Inverting Storage Wrapper

This block holds a small array of sensitive words in flip-flops and keeps each storage cell from holding the same bit value for long. A programmable timer starts a refresh pass. The pass walks the array one word per cycle and writes back the bitwise complement of each word. A polarity flag records whether the stored image as a whole is true or inverted. During a pass, a pass pointer splits the array: words below the pointer already hold the new polarity, and words at or above it still hold the old one.

The host sees none of this. It reads and writes through a single port. Reads are XORed with the polarity that applies to the addressed word, so they always return true data. Writes are stored in that same polarity. A host access always wins arbitration and holds the pass back for that cycle. The period register is loaded through its own write strobe. A value of zero disables the timer.

The sequencer has three states:
- `ST_IDLE`: the timer runs.
- `ST_SWEEP`: one word is complemented per free cycle.
- `ST_FLIP`: the polarity flag toggles and the pointer clears.

Transitions:
- `ST_IDLE`→`ST_SWEEP` on a timer tick.
- `ST_SWEEP`→`ST_SWEEP` while words remain, or on a stalled cycle.
- `ST_SWEEP`→`ST_FLIP` after the last word is rewritten.
- `ST_FLIP`→`ST_IDLE` always.

Top module: `inv_store_top`

## Requirements
- R1: After reset, `inverted` is 0, `busy` is 0, the period is 0 (timer off) and every word reads back as 0.
- R2: A read (`host_req`=1, `host_we`=0) raises `host_rvalid` on the next cycle, with `host_rdata` equal to the last value written to that address, whatever the polarity or pass progress.
- R3: A write issued in any state, including mid-pass and in the finish cycle, is returned unchanged by later reads.
- R4: After the period is written with P>0, `busy` stays low for exactly P cycles before a pass begins. With P=0 no pass ever starts.
- R5: A pass with no host traffic keeps `busy` high for exactly DEPTH+1 cycles: one sweep cycle per word plus one finish cycle. The pass pointer advances by one on each unstalled sweep cycle.
- R6: `inverted` toggles exactly once per pass, on the cycle `busy` falls, and at no other time.
- R7: Every cycle with `host_req` high during the sweep stalls the pass. The pointer holds, and the pass lasts one cycle longer per stalled cycle.
- R8: After a pass ends, the timer restarts from zero, so consecutive passes are separated by exactly P idle cycles.
- R9: While a pass is part-way through (words below the pointer inverted, the rest not), reads and writes to both halves return true data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_req | input | 1 | Host access strobe |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | AW | Word address |
| host_wdata | input | WIDTH | Write data (true value) |
| host_rdata | output | WIDTH | Read data (true value), valid with host_rvalid |
| host_rvalid | output | 1 | Read data valid, one cycle after a read request |
| period_we | input | 1 | Load the refresh period register |
| period_wdata | input | PW | Refresh period in idle cycles; 0 disables the timer |
| busy | output | 1 | A refresh pass is in progress |
| inverted | output | 1 | Stored image is currently held complemented |

## Verification
The collision that matters is a host access landing in the same cycle as a refresh step. The bench provokes it in three ways:
- It holds back-to-back reads at the very start of a sweep.
- It writes to addresses on both sides of a part-way pointer.
- It writes in the finish cycle, when the polarity flips.

Each case is judged in two ways. The bench reads every word back against its own array of true values. It also requires the pass length to grow by exactly the number of stalled sweep cycles.

// File: rtl/inv_store_pkg.sv
package inv_store_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SWEEP = 2'd1,
        ST_FLIP  = 2'd2
    } pass_state_t;

endpackage

// File: rtl/inv_store_timer.sv
module inv_store_timer #(
    parameter int PW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          period_we,
    input  logic [PW-1:0] period_wdata,
    input  logic          run,
    output logic          tick,
    output logic [PW-1:0] period_q
);

    logic [PW-1:0] cnt_q;

    // period register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            period_q <= '0;
        end else if (period_we) begin
            period_q <= period_wdata;
        end
    end

    assign tick = run && (period_q != '0) && (cnt_q == period_q - 1'b1);

    // idle-cycle counter, cleared whenever a pass runs or the period changes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (period_we || !run || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/inv_store_seq.sv
module inv_store_seq
    import inv_store_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int PTRW = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic            host_req,
    output pass_state_t     state,
    output logic [PTRW-1:0] ptr,
    output logic            pol,
    output logic            ref_en,
    output logic            run_timer,
    output logic            pass_active
);

    localparam logic [PTRW-1:0] LAST = PTRW'(DEPTH - 1);

    pass_state_t state_d;

    // next-state logic
    always_comb begin
        state_d = state;
        unique case (state)
            ST_IDLE:  if (tick) state_d = ST_SWEEP;
            ST_SWEEP: if (!host_req && ptr == LAST) state_d = ST_FLIP;
            ST_FLIP:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_d;
    end

    // outputs
    always_comb begin
        ref_en      = 1'b0;
        run_timer   = 1'b0;
        pass_active = 1'b1;
        unique case (state)
            ST_IDLE: begin
                run_timer   = 1'b1;
                pass_active = 1'b0;
            end
            ST_SWEEP: ref_en = !host_req;
            ST_FLIP:  ;
            default:  ;
        endcase
    end

    // pass pointer and polarity
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr <= '0;
            pol <= 1'b0;
        end else begin
            if (ref_en) ptr <= ptr + 1'b1;
            if (state == ST_FLIP) begin
                ptr <= '0;
                pol <= ~pol;
            end
        end
    end

endmodule

// File: rtl/inv_store_bank.sv
module inv_store_bank #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int PTRW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_req,
    input  logic             host_we,
    input  logic [AW-1:0]    host_addr,
    input  logic [WIDTH-1:0] host_wdata,
    output logic [WIDTH-1:0] host_rdata,
    output logic             host_rvalid,
    input  logic             ref_en,
    input  logic [PTRW-1:0]  ptr,
    input  logic             pol,
    input  logic             pass_active
);

    logic [WIDTH-1:0] word_q [DEPTH];
    logic             host_pol;
    logic [WIDTH-1:0] host_mask;

    // words below the pointer already carry the new polarity
    assign host_pol  = pol ^ (pass_active && (PTRW'(host_addr) < ptr));
    assign host_mask = {WIDTH{host_pol}};

    for (genvar i = 0; i < DEPTH; i++) begin : g_word
        logic hit_wr;
        logic hit_ref;
        assign hit_wr  = host_req && host_we && (host_addr == AW'(i));
        assign hit_ref = ref_en && (ptr == PTRW'(i));
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       word_q[i] <= '0;
            else if (hit_wr)  word_q[i] <= host_wdata ^ host_mask;
            else if (hit_ref) word_q[i] <= ~word_q[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            host_rdata  <= '0;
            host_rvalid <= 1'b0;
        end else begin
            host_rvalid <= host_req && !host_we;
            if (host_req && !host_we) host_rdata <= word_q[host_addr] ^ host_mask;
        end
    end

endmodule

// File: rtl/inv_store_top.sv
module inv_store_top
    import inv_store_pkg::*;
#(
    parameter int WIDTH = 8,
    parameter int DEPTH = 8,
    parameter int PW    = 32,
    localparam int AW   = $clog2(DEPTH),
    localparam int PTRW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_req,
    input  logic             host_we,
    input  logic [AW-1:0]    host_addr,
    input  logic [WIDTH-1:0] host_wdata,
    output logic [WIDTH-1:0] host_rdata,
    output logic             host_rvalid,
    input  logic             period_we,
    input  logic [PW-1:0]    period_wdata,
    output logic             busy,
    output logic             inverted
);

    pass_state_t     state;
    logic [PTRW-1:0] ptr;
    logic            pol;
    logic            ref_en;
    logic            run_timer;
    logic            pass_active;
    logic            tick;
    logic [PW-1:0]   period_q;

    inv_store_timer #(.PW(PW)) u_timer (
        .clk          (clk),
        .rst_n        (rst_n),
        .period_we    (period_we),
        .period_wdata (period_wdata),
        .run          (run_timer),
        .tick         (tick),
        .period_q     (period_q)
    );

    inv_store_seq #(.DEPTH(DEPTH)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick),
        .host_req    (host_req),
        .state       (state),
        .ptr         (ptr),
        .pol         (pol),
        .ref_en      (ref_en),
        .run_timer   (run_timer),
        .pass_active (pass_active)
    );

    inv_store_bank #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .host_req    (host_req),
        .host_we     (host_we),
        .host_addr   (host_addr),
        .host_wdata  (host_wdata),
        .host_rdata  (host_rdata),
        .host_rvalid (host_rvalid),
        .ref_en      (ref_en),
        .ptr         (ptr),
        .pol         (pol),
        .pass_active (pass_active)
    );

    assign busy     = pass_active;
    assign inverted = pol;

endmodule

// File: rtl/inv_store_chk.sv
module inv_store_chk
    import inv_store_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int PW    = 32,
    localparam int PTRW = $clog2(DEPTH + 1)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            host_req,
    input logic            host_we,
    input logic            host_rvalid,
    input logic            busy,
    input logic            inverted,
    input pass_state_t     state,
    input logic [PTRW-1:0] ptr,
    input logic [PW-1:0]   period_q
);

    AST_READ_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (host_req && !host_we) |=> host_rvalid); // R2

    AST_TIMER_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (period_q == '0 && !busy) |=> !busy); // R4

    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SWEEP && !host_req) |=> (ptr == PTRW'($past(ptr) + 1'b1))); // R5

    AST_PTR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        ptr <= PTRW'(DEPTH)); // R5

    AST_FLIP_ONLY_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(inverted) |-> $fell(busy)); // R6

    AST_END_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !$stable(inverted)); // R6

    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SWEEP && host_req) |=> $stable(ptr)); // R7

    AST_IDLE_PTR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> ptr == '0); // R9

endmodule

bind inv_store_top inv_store_chk #(.DEPTH(DEPTH), .PW(PW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_req    (host_req),
    .host_we     (host_we),
    .host_rvalid (host_rvalid),
    .busy        (busy),
    .inverted    (inverted),
    .state       (state),
    .ptr         (ptr),
    .period_q    (period_q)
);

// File: tb/tb_inv_store_top.sv
module tb_inv_store_top;

    localparam int WIDTH = 8;
    localparam int DEPTH = 8;
    localparam int PW    = 16;
    localparam int AW    = $clog2(DEPTH);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             host_req = 1'b0;
    logic             host_we = 1'b0;
    logic [AW-1:0]    host_addr = '0;
    logic [WIDTH-1:0] host_wdata = '0;
    logic [WIDTH-1:0] host_rdata;
    logic             host_rvalid;
    logic             period_we = 1'b0;
    logic [PW-1:0]    period_wdata = '0;
    logic             busy;
    logic             inverted;

    int n_chk = 0;
    int n_bad = 0;
    logic [WIDTH-1:0] model [DEPTH];

    always #2 clk = ~clk;

    inv_store_top #(.WIDTH(WIDTH), .DEPTH(DEPTH), .PW(PW)) dut (.*);

    task automatic check(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_write(input int a, input logic [WIDTH-1:0] d);
        host_req = 1'b1; host_we = 1'b1; host_addr = AW'(a); host_wdata = d;
        @(negedge clk);
        host_req = 1'b0; host_we = 1'b0;
        model[a] = d;
    endtask

    task automatic do_read(input int a, input string req);
        host_req = 1'b1; host_we = 1'b0; host_addr = AW'(a);
        @(negedge clk);
        host_req = 1'b0;
        check(req, host_rvalid, 1);
        check(req, host_rdata, model[a]);
    endtask

    task automatic read_all(input string req);
        for (int a = 0; a < DEPTH; a++) do_read(a, req);
    endtask

    task automatic set_period(input int p);
        period_we = 1'b1; period_wdata = PW'(p);
        @(negedge clk);
        period_we = 1'b0;
    endtask

    task automatic count_idle(output int n);
        n = 0;
        while (!busy && n < 1000) begin n++; @(negedge clk); end
    endtask

    task automatic count_busy(output int n);
        n = 0;
        while (busy && n < 1000) begin n++; @(negedge clk); end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        int idle_n, busy_n;
        logic pol_before;
        for (int a = 0; a < DEPTH; a++) model[a] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 busy", busy, 0);
        check("R1 inverted", inverted, 0);
        repeat (20) @(negedge clk);
        check("R1 timer off", busy, 0);
        read_all("R1 zero contents");

        // R2 R3 fill with distinct values and read back
        for (int a = 0; a < DEPTH; a++) do_write(a, WIDTH'(a * 37 + 5));
        read_all("R2 true data");

        // R4 R5 R6 R8 period sweep
        for (int p = 1; p <= 6; p++) begin
            set_period(p);
            for (int k = 0; k < 2; k++) begin
                pol_before = inverted;
                count_idle(idle_n);
                check(k == 0 ? "R4 idle gap" : "R8 idle gap", idle_n, p);
                count_busy(busy_n);
                check("R5 pass length", busy_n, DEPTH + 1);
                check("R6 flag toggled", inverted, !pol_before);
            end
            set_period(0);
            if (busy) count_busy(busy_n);
            read_all("R2 after passes");
        end

        // R4 period zero keeps timer off
        repeat (40) @(negedge clk);
        check("R4 disabled", busy, 0);

        // R7 stalls: five reads at the start of a sweep
        set_period(3);
        count_idle(idle_n);
        for (int s = 0; s < 5; s++) do_read(s, "R7 read during stall");
        busy_n = 5;
        while (busy && busy_n < 1000) begin busy_n++; @(negedge clk); end
        check("R7 stalled pass length", busy_n, DEPTH + 1 + 5);

        // R9 mixed polarity: writes below and above the pointer
        count_idle(idle_n);
        repeat (3) @(negedge clk);
        check("R9 still busy", busy, 1);
        do_write(1, 8'hA5);
        do_write(DEPTH - 2, 8'h3C);
        read_all("R9 mixed-polarity read");
        if (busy) count_busy(busy_n);
        read_all("R9 after pass");

        // R3 write in the finish cycle
        count_idle(idle_n);
        repeat (DEPTH) @(negedge clk);
        pol_before = inverted;
        do_write(5, 8'hC3);
        check("R3 flag flipped at finish", inverted, !pol_before);
        check("R3 idle after finish", busy, 0);
        set_period(0);
        if (busy) count_busy(busy_n);
        read_all("R3 finish-cycle write");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule